// File: doc/BRIEF.md
# Vector Element Move Unit

This unit moves data between a 64-bit scalar value and a 128-bit vector value, split into lanes of one of four sizes. It offers three kinds of transfer. A copy pulls one lane out of the vector into the scalar result, sign-extended or zero-extended. An insert overwrites one chosen lane of the vector with the low bits of the scalar and leaves every other lane as it was. A fill writes the low bits of the scalar into every lane.

A request is a one-cycle `start` pulse together with the operation, the lane format, the lane index and both operands. On the next clock edge the unit registers its results, a one-cycle `done` pulse and a write-enable for whichever result it updated. The caller owns the register files and uses the write-enables to decide what to write back. An index that does not fit the chosen format is reported and nothing is written.

Top module: `vec_elem_mover`

## Requirements
- R1: After a synchronous reset, `scalar_out` and `vec_out` are zero and `done`, `scalar_we`, `vec_we` and `idx_err` are low.
- R2: Operation code 0 (signed copy) returns lane `idx` of `vec_in`, where lane n of width W occupies bits [n*W +: W]. A byte, half or word lane is sign-extended to 64 bits; a doubleword lane is returned unchanged.
- R3: Operation code 1 (unsigned copy) returns lane `idx` zero-extended to 64 bits, so only the lane's own width of bits can be nonzero.
- R4: Operation code 2 (insert) sets lane `idx` of the vector result to the low W bits of `scalar_in`; every other lane equals the same lane of `vec_in`.
- R5: Operation code 3 (fill) sets every lane of the vector result to the low W bits of `scalar_in`; for doublewords both halves receive the full scalar. The index is ignored and a fill never reports an error.
- R6: Format code 0 is byte (16 lanes), 1 is halfword (8 lanes), 2 is word (4 lanes), 3 is doubleword (2 lanes). The highest valid index is the lane count minus one.
- R7: A copy or insert whose index is at or above the lane count raises `idx_err` for one cycle, keeps both write-enables low, and leaves `scalar_out` and `vec_out` unchanged.
- R8: A valid copy raises only `scalar_we` and updates only `scalar_out`; a valid insert or fill raises only `vec_we` and updates only `vec_out`.
- R9: Results, `done` and the flags appear on the clock edge after `start`; `done`, the write-enables and `idx_err` are high for that one cycle only and low in any cycle that does not follow a `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request pulse |
| op | input | 2 | Operation: 0 signed copy, 1 unsigned copy, 2 insert, 3 fill |
| fmt | input | 2 | Lane format: 0 byte, 1 half, 2 word, 3 doubleword |
| idx | input | 4 | Lane index |
| scalar_in | input | 64 | Scalar operand |
| vec_in | input | 128 | Vector operand |
| scalar_out | output | 64 | Registered scalar result |
| vec_out | output | 128 | Registered vector result |
| scalar_we | output | 1 | Scalar result was updated this cycle |
| vec_we | output | 1 | Vector result was updated this cycle |
| idx_err | output | 1 | Index was out of range for the format |
| done | output | 1 | Request completed |

## Verification
The bench builds the unit with its default 128-bit vector, which gives a 4-bit index field. That width lets every format be driven with indices beyond its lane count (2 to 15 for doublewords, 4 to 15 for words, 8 to 15 for halves), so the error path is reached for three of the four formats, while the byte format reaches its top lane 15 as a valid boundary. Random operands with the top bit of each lane set exercise sign extension against zero extension in every lane position.

// File: rtl/vem_pkg.sv
package vem_pkg;

  localparam int SCL_W = 64;

  typedef enum logic [1:0] {
    OP_COPY_S = 2'd0,
    OP_COPY_U = 2'd1,
    OP_INSERT = 2'd2,
    OP_FILL   = 2'd3
  } vem_op_e;

  typedef enum logic [1:0] {
    FMT_BYTE = 2'd0,
    FMT_HALF = 2'd1,
    FMT_WORD = 2'd2,
    FMT_DBL  = 2'd3
  } vem_fmt_e;

  // Byte offset inside a lane for a given byte position of the vector.
  function automatic logic [2:0] lane_byte_off(logic [2:0] pos, logic [1:0] fmt);
    logic [2:0] mask;
    mask = (3'd1 << fmt) - 3'd1;
    return pos & mask;
  endfunction

endpackage

// File: rtl/vem_fmt_decode.sv
module vem_fmt_decode #(
  parameter int NBYTES = 16,
  parameter int IDX_W  = 4
) (
  input  logic [1:0]       fmt,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W:0]   lane_cnt,
  output logic             idx_ok
);

  localparam logic [IDX_W:0] NB = (IDX_W+1)'(NBYTES);

  always_comb begin
    lane_cnt = NB >> fmt;
    idx_ok   = ({1'b0, idx} < lane_cnt);
  end

endmodule

// File: rtl/vem_extract.sv
module vem_extract
  import vem_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int IDX_W = 4
) (
  input  logic [1:0]       fmt,
  input  logic [IDX_W-1:0] idx,
  input  logic             sgn,
  input  logic [VEC_W-1:0] vec,
  output logic [SCL_W-1:0] elem
);

  function automatic logic [SCL_W-1:0] pick_lane(
    logic [VEC_W-1:0] v, logic [1:0] f, logic [IDX_W-1:0] n, logic s);
    logic [VEC_W-1:0] sh;
    int unsigned      amt;
    logic [SCL_W-1:0] r;
    amt = int'(n) * (8 << f);
    sh  = v >> amt;
    case (f)
      FMT_BYTE: r = s ? {{56{sh[7]}},  sh[7:0]}  : {56'd0, sh[7:0]};
      FMT_HALF: r = s ? {{48{sh[15]}}, sh[15:0]} : {48'd0, sh[15:0]};
      FMT_WORD: r = s ? {{32{sh[31]}}, sh[31:0]} : {32'd0, sh[31:0]};
      default:  r = sh[SCL_W-1:0];
    endcase
    return r;
  endfunction

  always_comb elem = pick_lane(vec, fmt, idx, sgn);

endmodule

// File: rtl/vem_lane_write.sv
module vem_lane_write
  import vem_pkg::*;
#(
  parameter int NBYTES = 16,
  parameter int IDX_W  = 4
) (
  input  logic [1:0]          fmt,
  input  logic [IDX_W-1:0]    idx,
  input  logic                fill,
  input  logic [SCL_W-1:0]    scalar,
  input  logic [8*NBYTES-1:0] vec,
  output logic [8*NBYTES-1:0] vec_new,
  output logic [NBYTES-1:0]   byte_sel
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam logic [IDX_W-1:0] BPOS = IDX_W'(b);
    localparam logic [2:0]       BLOW = 3'(b);
    logic [2:0] off;
    always_comb begin
      off         = lane_byte_off(BLOW, fmt);
      byte_sel[b] = fill | ((BPOS >> fmt) == idx);
      vec_new[8*b +: 8] = byte_sel[b] ? scalar[{off, 3'b000} +: 8]
                                      : vec[8*b +: 8];
    end
  end

endmodule

// File: rtl/vec_elem_mover.sv
module vec_elem_mover
  import vem_pkg::*;
#(
  parameter  int VEC_W  = 128,
  localparam int NBYTES = VEC_W / 8,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [1:0]       fmt,
  input  logic [IDX_W-1:0] idx,
  input  logic [SCL_W-1:0] scalar_in,
  input  logic [VEC_W-1:0] vec_in,
  output logic [SCL_W-1:0] scalar_out,
  output logic [VEC_W-1:0] vec_out,
  output logic             scalar_we,
  output logic             vec_we,
  output logic             idx_err,
  output logic             done
);

  // Named internal events, also watched by the checker.
  logic [IDX_W:0]   lane_cnt;
  logic             idx_ok;
  logic [SCL_W-1:0] copy_val;
  logic [VEC_W-1:0] lane_val;
  logic [NBYTES-1:0] byte_sel;
  logic             is_copy;
  logic             is_fill;

  assign is_copy = (op == OP_COPY_S) || (op == OP_COPY_U);
  assign is_fill = (op == OP_FILL);

  vem_fmt_decode #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_dec (
    .fmt      (fmt),
    .idx      (idx),
    .lane_cnt (lane_cnt),
    .idx_ok   (idx_ok)
  );

  vem_extract #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_ext (
    .fmt  (fmt),
    .idx  (idx),
    .sgn  (op == OP_COPY_S),
    .vec  (vec_in),
    .elem (copy_val)
  );

  vem_lane_write #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_wr (
    .fmt      (fmt),
    .idx      (idx),
    .fill     (is_fill),
    .scalar   (scalar_in),
    .vec      (vec_in),
    .vec_new  (lane_val),
    .byte_sel (byte_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scalar_out <= '0;
      vec_out    <= '0;
      scalar_we  <= 1'b0;
      vec_we     <= 1'b0;
      idx_err    <= 1'b0;
      done       <= 1'b0;
    end else begin
      done      <= start;
      scalar_we <= 1'b0;
      vec_we    <= 1'b0;
      idx_err   <= 1'b0;
      if (start) begin
        if (!is_fill && !idx_ok) begin
          idx_err <= 1'b1;
        end else if (is_copy) begin
          scalar_out <= copy_val;
          scalar_we  <= 1'b1;
        end else begin
          vec_out <= lane_val;
          vec_we  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vem_chk.sv
module vem_chk #(
  parameter int VEC_W  = 128,
  parameter int NBYTES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        op,
  input logic [VEC_W-1:0]  vec_in,
  input logic              idx_ok,
  input logic [NBYTES-1:0] byte_sel,
  input logic [63:0]       scalar_out,
  input logic [VEC_W-1:0]  vec_out,
  input logic              scalar_we,
  input logic              vec_we,
  input logic              idx_err,
  input logic              done
);

  logic [VEC_W-1:0] bit_mask;
  always_comb begin
    for (int b = 0; b < NBYTES; b++) bit_mask[8*b +: 8] = {8{byte_sel[b]}};
  end

  // R9
  done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  // R9
  quiet_without_start_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!done && !scalar_we && !vec_we && !idx_err));

  // R8
  single_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scalar_we, vec_we, idx_err}));

  // R7
  bad_index_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op != 2'd3 && !idx_ok) |=> idx_err);

  // R7
  error_holds_data_chk: assert property (@(posedge clk) disable iff (rst)
    idx_err |-> ($stable(scalar_out) && $stable(vec_out)));

  // R5
  fill_always_writes_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op == 2'd3) |=> (vec_we && !idx_err));

  // R4
  insert_keeps_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op == 2'd2 && idx_ok) |=>
      (((vec_out ^ $past(vec_in)) & ~$past(bit_mask)) == '0));

  // R8
  copy_keeps_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !op[1]) |=> $stable(vec_out));

endmodule

bind vec_elem_mover vem_chk #(.VEC_W(VEC_W), .NBYTES(NBYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .op         (op),
  .vec_in     (vec_in),
  .idx_ok     (idx_ok),
  .byte_sel   (byte_sel),
  .scalar_out (scalar_out),
  .vec_out    (vec_out),
  .scalar_we  (scalar_we),
  .vec_we     (vec_we),
  .idx_err    (idx_err),
  .done       (done)
);

// File: tb/vec_elem_mover_test.sv
module vec_elem_mover_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   op = '0;
  logic [1:0]   fmt = '0;
  logic [3:0]   idx = '0;
  logic [63:0]  scalar_in = '0;
  logic [127:0] vec_in = '0;
  logic [63:0]  scalar_out;
  logic [127:0] vec_out;
  logic         scalar_we, vec_we, idx_err, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [63:0]  m_scal = '0;
  logic [127:0] m_vec = '0;

  always #4 clk = ~clk;

  vec_elem_mover uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .fmt(fmt), .idx(idx),
    .scalar_in(scalar_in), .vec_in(vec_in), .scalar_out(scalar_out),
    .vec_out(vec_out), .scalar_we(scalar_we), .vec_we(vec_we),
    .idx_err(idx_err), .done(done)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int lanes_of(logic [1:0] f);
    return 16 / (1 << f);
  endfunction

  function automatic logic [63:0] model_copy(logic [127:0] v, logic [1:0] f,
                                             logic [3:0] n, bit sgn);
    int w = 8 * (1 << f);
    logic [63:0] e = '0;
    for (int k = 0; k < w; k++) e[k] = v[int'(n) * w + k];
    if (sgn) for (int k = w; k < 64; k++) e[k] = e[w-1];
    return e;
  endfunction

  function automatic logic [127:0] model_write(logic [127:0] v, logic [63:0] s,
                                               logic [1:0] f, logic [3:0] n, bit all);
    int w = 8 * (1 << f);
    logic [127:0] r = v;
    for (int l = 0; l < lanes_of(f); l++)
      if (all || l == int'(n))
        for (int k = 0; k < w; k++) r[l*w + k] = s[k];
    return r;
  endfunction

  task automatic run_op(logic [1:0] o, logic [1:0] f, logic [3:0] n,
                        logic [63:0] s, logic [127:0] v, string req);
    bit ok;
    logic exp_sw, exp_vw, exp_err;
    ok = (o == 2'd3) || (int'(n) < lanes_of(f));
    exp_sw = ok && !o[1];
    exp_vw = ok && o[1];
    exp_err = !ok;
    if (ok) begin
      if (!o[1]) m_scal = model_copy(v, f, n, o == 2'd0);
      else m_vec = model_write(v, s, f, n, o == 2'd3);
    end
    @(negedge clk);
    op = o; fmt = f; idx = n; scalar_in = s; vec_in = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 done", 128'(done), 128'(1'b1));
    check("R8 scalar_we", 128'(scalar_we), 128'(exp_sw));
    check("R8 vec_we", 128'(vec_we), 128'(exp_vw));
    check("R7 idx_err", 128'(idx_err), 128'(exp_err));
    check({req, " scalar_out"}, 128'(scalar_out), 128'(m_scal));
    check({req, " vec_out"}, vec_out, m_vec);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [127:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 scalar_out", 128'(scalar_out), '0);
    check("R1 vec_out", vec_out, '0);
    check("R1 flags", 128'({done, scalar_we, vec_we, idx_err}), '0);

    v = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E80;
    // R2 signed byte copy of negative lane 0
    run_op(2'd0, 2'd0, 4'd0, '0, v, "R2");
    check("R2 sign", 128'(scalar_out), 128'(64'hFFFF_FFFF_FFFF_FF80));
    // R3 unsigned byte copy of same lane
    run_op(2'd1, 2'd0, 4'd0, '0, v, "R3");
    check("R3 zero", 128'(scalar_out), 128'(64'h80));
    // R2 doubleword copy unchanged, R6 top dword lane
    run_op(2'd0, 2'd3, 4'd1, '0, v, "R2");
    check("R2 dword", 128'(scalar_out), 128'(64'hF0E1D2C3_B4A59687));
    // R3 unsigned word lane 3
    run_op(2'd1, 2'd2, 4'd3, '0, v, "R3");
    check("R3 word", 128'(scalar_out), 128'(64'hF0E1D2C3));
    // R6 top byte lane valid
    run_op(2'd0, 2'd0, 4'd15, '0, v, "R6");
    // R4 insert half into lane 7
    run_op(2'd2, 2'd1, 4'd7, 64'h1234_5678_9ABC_DEF0, v, "R4");
    check("R4 lane7", vec_out, {16'hDEF0, v[111:0]});
    // R5 fill byte, index 15 ignored
    run_op(2'd3, 2'd0, 4'd15, 64'hAA, v, "R5");
    check("R5 fill", vec_out, {16{8'hAA}});
    // R5 fill dword with out-of-range index ignored
    run_op(2'd3, 2'd3, 4'd9, 64'h0123_4567_89AB_CDEF, v, "R5");
    // R7 / R6 dword index 2 out of range, outputs hold
    run_op(2'd0, 2'd3, 4'd2, 64'h55, v, "R7");
    run_op(2'd2, 2'd2, 4'd4, 64'h55, v, "R7");
    run_op(2'd2, 2'd1, 4'd8, 64'h55, v, "R6");
    // R9 no start: flags low next cycle
    @(negedge clk);
    check("R9 idle", 128'({done, scalar_we, vec_we, idx_err}), '0);

    for (int i = 0; i < 600; i++) begin
      logic [1:0] o, f;
      logic [3:0] n;
      o = 2'($urandom);
      f = 2'($urandom);
      if (($urandom % 5) == 0) n = 4'($urandom);
      else n = 4'($urandom % lanes_of(f));
      run_op(o, f, n, {$urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom},
             o[1] ? (o[0] ? "R5" : "R4") : (o[0] ? "R3" : "R2"));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule